// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Zero Bus Turnaround

A behavioural synchronous static memory whose read data leaves the array combinationally from the registered address. A read therefore shows its data in the same cycle that follows the clock edge which took its address. Write data trails its address and control by one clock. Because of this offset, reads and writes can alternate on every cycle without any dead cycle on the data bus. A write whose data has been taken but not yet committed to the array is forwarded to any read of the same word, one lane at a time.

Every address, control and byte-lane input is registered on the rising clock edge. Three chip-select inputs must all be at their active levels for a new access to start. A load or advance strobe chooses between starting a new access and stepping a two-bit burst counter over the low address bits. The step order is either linear or interleaved, and it always wraps inside an aligned group of four words. A sleep input makes the device ignore whatever is presented on that edge. The bidirectional data bus is modelled as a data input, a data output and an output-drive flag. The array depth is `2**ADDR_W`. Setting `ADDR_W = 17` gives the full 128K-word part; the default is kept smaller for elaboration.

Top module: `ftsram_top`

## Requirements
- R1: The array holds `2**ADDR_W` words of `LANES*LANE_W` bits (18 by default), and a word written to an address is returned by a later read of that address.
- R2: Every input except `rd_oe_n` is sampled at the rising clock edge. The read data for an address captured at edge n is driven on `dout` during the cycle between edge n and edge n+1, with no output register.
- R3: Write data on `din` is sampled at the edge after the one that captured the write's address. Writes and reads may alternate on consecutive edges with no idle cycle.
- R4: A load is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load under any other combination is a deselect: nothing is written, `dout_en` stays low in the following cycle, and the burst ends.
- R5: When `advance`=1 the burst counter steps by one and sets address bits [1:0]; the upper bits keep the loaded value. For start offset s and step k, the low bits are (s+k) mod 4 when `lin_order` was 1 at the load, and s XOR k when it was 0. After four steps the counter returns to s.
- R6: A beat started by `advance` repeats the direction (read or write) of the load that opened the burst. Each write beat uses the lane enables sampled on its own edge. An advance with no burst open performs no access.
- R7: On an edge where `sleep_req`=1 the access is ignored: no write, no output in the following cycle, and the burst counter and direction are unchanged.
- R8: A read whose address matches a write whose data is still pending returns the pending data in each lane that write enables. The other lanes come from the array.
- R9: `lane_wr_n[0]`=0 writes bits [LANE_W-1:0] and `lane_wr_n[1]`=0 writes bits [2*LANE_W-1:LANE_W]. A lane whose enable is 1 keeps its previous contents.
- R10: `dout_en` is 1 only during the output cycle of a read while `rd_oe_n`=0. Otherwise `dout` is all zeros, which stands for high impedance.
- R11: Synchronous reset (`rst`=1) leaves no access or pending write in flight and no burst open, so `dout_en` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Word address for a load |
| advance | input | 1 | 1 steps the burst, 0 loads a new address |
| wr_n | input | 1 | 0 makes a load a write, 1 a read |
| lane_wr_n | input | LANES | Active-low write enable per lane |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| sleep_req | input | 1 | 1 ignores the access on this edge |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| rd_oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | LANES*LANE_W | Write data, one cycle after its address |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | 1 while dout drives the bus |

## Verification
The bench builds the block with `ADDR_W = 8` and keeps the two 9-bit lanes. A 256-word array is cheap, but it still contains several aligned four-word groups, so both burst orders and their wrap can be seen in different groups. Address bits above the counter take several values, which shows that advances never disturb them. The 18-bit word keeps the real lane split, so partial writes and per-lane forwarding of pending data are observed on genuine 9-bit boundaries.

// File: rtl/ftsram_pkg.sv
`timescale 1ns/1ps
package ftsram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    localparam int STEP_W = 2;

    // Low address bits for a burst beat: linear adds the step, interleaved XORs it.
    function automatic logic [STEP_W-1:0] beat_low(input logic [STEP_W-1:0] start,
                                                   input logic [STEP_W-1:0] step,
                                                   input logic             linear);
        return linear ? (start + step) : (start ^ step);
    endfunction

endpackage

// File: rtl/ftsram_ctrl.sv
`timescale 1ns/1ps
module ftsram_ctrl
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int LANES  = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              advance,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              sleep_req,
    input  logic              lin_order,
    output op_e               op_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [LANES-1:0]  lanes_q
);
    localparam int HI_W = ADDR_W - STEP_W;

    logic              chip_sel;
    op_e               burst_op;
    logic [HI_W-1:0]   burst_hi;
    logic [STEP_W-1:0] burst_start;
    logic [STEP_W-1:0] burst_cnt;
    logic              burst_lin;
    logic [STEP_W-1:0] cnt_nxt;

    assign chip_sel = !sel_a_n && sel_b && !sel_c_n;
    assign cnt_nxt  = burst_cnt + STEP_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q        <= OP_IDLE;
            burst_op    <= OP_IDLE;
            addr_q      <= '0;
            lanes_q     <= '1;
            burst_hi    <= '0;
            burst_start <= '0;
            burst_cnt   <= '0;
            burst_lin   <= 1'b1;
        end else begin
            lanes_q <= lane_wr_n;
            if (sleep_req) begin
                op_q <= OP_IDLE;
            end else if (!advance) begin
                if (chip_sel) begin
                    op_q        <= wr_n ? OP_READ : OP_WRITE;
                    burst_op    <= wr_n ? OP_READ : OP_WRITE;
                    burst_hi    <= addr[ADDR_W-1:STEP_W];
                    burst_start <= addr[STEP_W-1:0];
                    burst_cnt   <= '0;
                    burst_lin   <= lin_order;
                    addr_q      <= addr;
                end else begin
                    op_q     <= OP_IDLE;
                    burst_op <= OP_IDLE;
                end
            end else begin
                burst_cnt <= cnt_nxt;
                op_q      <= burst_op;
                addr_q    <= {burst_hi, beat_low(burst_start, cnt_nxt, burst_lin)};
            end
        end
    end

    assert_sleep_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        sleep_req |=> (op_q == OP_IDLE));

    assert_burst_stays_in_group_R5: assert property (@(posedge clk) disable iff (rst)
        (advance && !sleep_req) |=> (addr_q[ADDR_W-1:STEP_W] == $past(addr_q[ADDR_W-1:STEP_W])));

endmodule

// File: rtl/ftsram_wbuf.sv
`timescale 1ns/1ps
module ftsram_wbuf
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
)(
    input  logic                    clk,
    input  logic                    rst,
    input  op_e                     op_q,
    input  logic [ADDR_W-1:0]       addr_q,
    input  logic [LANES-1:0]        lanes_q,
    input  logic [LANES*LANE_W-1:0] din,
    output logic                    pend_vld,
    output logic [ADDR_W-1:0]       pend_addr,
    output logic [LANES-1:0]        pend_lanes_n,
    output logic [LANES*LANE_W-1:0] pend_data
);
    always_ff @(posedge clk) begin
        if (rst) pend_vld <= 1'b0;
        else     pend_vld <= (op_q == OP_WRITE);
    end

    always_ff @(posedge clk) begin
        pend_addr    <= addr_q;
        pend_lanes_n <= lanes_q;
        pend_data    <= din;
    end

    assert_wdata_one_late_R3: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_WRITE) |=> (pend_vld && pend_data == $past(din)));

endmodule

// File: rtl/ftsram_array.sv
`timescale 1ns/1ps
module ftsram_array #(
    parameter int ADDR_W = 11,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pend_vld,
    input  logic [ADDR_W-1:0]       pend_addr,
    input  logic [LANES-1:0]        pend_lanes_n,
    input  logic [LANES*LANE_W-1:0] pend_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] mem_rd;
    logic              hit;

    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (pend_vld && !pend_lanes_n[l])
                mem[pend_addr][l*LANE_W +: LANE_W] <= pend_data[l*LANE_W +: LANE_W];
        end
    end

    assign mem_rd = mem[rd_addr];
    assign hit    = pend_vld && (pend_addr == rd_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rdata[g*LANE_W +: LANE_W] = (hit && !pend_lanes_n[g])
                                         ? pend_data[g*LANE_W +: LANE_W]
                                         : mem_rd[g*LANE_W +: LANE_W];
    end

    assert_full_bypass_R8: assert property (@(posedge clk) disable iff (rst)
        (pend_vld && pend_addr == rd_addr && pend_lanes_n == '0) |-> (rdata == pend_data));

endmodule

// File: rtl/ftsram_top.sv
`timescale 1ns/1ps
module ftsram_top
    import ftsram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int LANES  = 2,
    parameter int LANE_W = 9
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    advance,
    input  logic                    wr_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    sleep_req,
    input  logic                    lin_order,
    input  logic                    rd_oe_n,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    localparam int DATA_W = LANES * LANE_W;

    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  lanes_q;
    logic              pend_vld;
    logic [ADDR_W-1:0] pend_addr;
    logic [LANES-1:0]  pend_lanes_n;
    logic [DATA_W-1:0] pend_data;
    logic [DATA_W-1:0] rdata;

    ftsram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst(rst), .addr(addr), .advance(advance), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .sleep_req(sleep_req), .lin_order(lin_order),
        .op_q(op_q), .addr_q(addr_q), .lanes_q(lanes_q)
    );

    ftsram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk(clk), .rst(rst), .op_q(op_q), .addr_q(addr_q), .lanes_q(lanes_q), .din(din),
        .pend_vld(pend_vld), .pend_addr(pend_addr), .pend_lanes_n(pend_lanes_n),
        .pend_data(pend_data)
    );

    ftsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .rst(rst), .pend_vld(pend_vld), .pend_addr(pend_addr),
        .pend_lanes_n(pend_lanes_n), .pend_data(pend_data),
        .rd_addr(addr_q), .rdata(rdata)
    );

    assign dout_en = (op_q == OP_READ) && !rd_oe_n;
    assign dout    = dout_en ? rdata : '0;

    assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (!advance && !sleep_req && !(!sel_a_n && sel_b && !sel_c_n)) |=> !dout_en);

endmodule

// File: tb/ftsram_top_bench.sv
`timescale 1ns/1ps
module ftsram_top_bench;
    localparam int AW     = 8;
    localparam int DW     = 18;
    localparam int WD_CYC = 200000;
    localparam logic [2:0] SEL = 3'b010;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          advance = 1'b0, wr_n = 1'b1;
    logic [1:0]    lane_wr_n = 2'b11;
    logic          sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
    logic          sleep_req = 1'b0, lin_order = 1'b1, rd_oe_n = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;

    always #2 clk = ~clk;

    ftsram_top #(.ADDR_W(AW), .LANES(2), .LANE_W(9)) u_ftsram_top (
        .clk(clk), .rst(rst), .addr(addr), .advance(advance), .wr_n(wr_n),
        .lane_wr_n(lane_wr_n), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .sleep_req(sleep_req), .lin_order(lin_order), .rd_oe_n(rd_oe_n),
        .din(din), .dout(dout), .dout_en(dout_en)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [DW-1:0] model [1 << AW];
    int            b_op    = 0;
    logic [AW-1:0] b_base  = '0;
    logic [1:0]    b_cnt   = '0;
    bit            b_lin   = 1;

    bit            q_en  [$];
    logic [DW-1:0] q_dat [$];
    string         q_req [$];

    // Driver: presents one access, then pushes what its output cycle must show.
    task automatic acc(input bit adv, input bit wr, input logic [1:0] bw,
                       input logic [AW-1:0] a, input logic [2:0] ce, input bit slp,
                       input bit lin, input bit oe, input logic [DW-1:0] wd, input string req);
        int op;
        logic [AW-1:0] ea;
        logic [1:0] lo;
        advance = adv; wr_n = !wr; lane_wr_n = bw; addr = a;
        {sel_a_n, sel_b, sel_c_n} = ce; sleep_req = slp; lin_order = lin;
        @(posedge clk); #1;
        rd_oe_n = oe;
        op = 0; ea = '0;
        if (slp) op = 0;
        else if (!adv) begin
            if (ce == SEL) begin
                op = wr ? 2 : 1; b_op = op; b_base = a; b_cnt = 2'd0; b_lin = lin; ea = a;
            end else b_op = 0;
        end else begin
            b_cnt = b_cnt + 2'd1;
            op = b_op;
            lo = b_lin ? (b_base[1:0] + b_cnt) : (b_base[1:0] ^ b_cnt);
            ea = {b_base[AW-1:2], lo};
        end
        if (op == 2) begin
            din = wd;
            if (!bw[0]) model[ea][8:0]  = wd[8:0];
            if (!bw[1]) model[ea][17:9] = wd[17:9];
        end
        q_en.push_back(op == 1 && !oe);
        q_dat.push_back(model[ea]);
        q_req.push_back(req);
    endtask

    task automatic idle(input string req);
        acc(0, 0, 2'b11, '0, 3'b101, 0, 1, 0, '0, req);
    endtask

    // Monitor: compares each output cycle at mid-cycle.
    always @(negedge clk) begin
        if (q_en.size() > 0) begin
            bit e; logic [DW-1:0] d; string r;
            e = q_en.pop_front(); d = q_dat.pop_front(); r = q_req.pop_front();
            checks++;
            if (dout_en !== e || (e && dout !== d) || (!e && dout !== '0)) begin
                fails++;
                $display("FAIL %s: dout_en=%0b dout=%h expected en=%0b data=%h",
                         r, dout_en, dout, e, e ? d : '0);
            end
        end
    end

    initial begin
        #(WD_CYC * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (dout_en !== 1'b0 || dout !== '0) begin
            fails++;
            $display("FAIL R11: dout_en=%0b dout=%h expected en=0 data=0", dout_en, dout);
        end
        @(posedge clk); #1;
        // R11: advance with no burst open after reset does nothing
        acc(1, 0, 2'b11, 8'h00, SEL, 0, 1, 0, '0, "R11 advance after reset");
        // R1 R2: plain writes then reads
        acc(0, 1, 2'b00, 8'h10, SEL, 0, 1, 0, 18'h2A5A5, "R1 write");
        acc(0, 1, 2'b00, 8'h11, SEL, 0, 1, 0, 18'h15A5A, "R1 write");
        idle("R1 gap");
        acc(0, 0, 2'b11, 8'h10, SEL, 0, 1, 0, '0, "R1 R2 read 10");
        acc(0, 0, 2'b11, 8'h11, SEL, 0, 1, 0, '0, "R1 R2 read 11");
        // R3 R8: back-to-back alternation, reads hit pending writes
        acc(0, 1, 2'b00, 8'h20, SEL, 0, 1, 0, 18'h0F0F0, "R3 write 20");
        acc(0, 0, 2'b11, 8'h20, SEL, 0, 1, 0, '0, "R8 read pending 20");
        acc(0, 1, 2'b00, 8'h21, SEL, 0, 1, 0, 18'h30303, "R3 write 21");
        acc(0, 0, 2'b11, 8'h10, SEL, 0, 1, 0, '0, "R3 read 10 between writes");
        acc(0, 1, 2'b00, 8'h22, SEL, 0, 1, 0, 18'h0ABCD, "R3 write 22");
        acc(0, 0, 2'b11, 8'h21, SEL, 0, 1, 0, '0, "R3 read 21");
        acc(0, 0, 2'b11, 8'h22, SEL, 0, 1, 0, '0, "R8 read 22");
        // R9: lane writes
        acc(0, 1, 2'b10, 8'h10, SEL, 0, 1, 0, 18'h3FFFF, "R9 lane0 only");
        idle("R9 gap");
        acc(0, 0, 2'b11, 8'h10, SEL, 0, 1, 0, '0, "R9 read lane0 write");
        acc(0, 1, 2'b01, 8'h11, SEL, 0, 1, 0, 18'h00000, "R9 lane1 only");
        acc(0, 0, 2'b11, 8'h11, SEL, 0, 1, 0, '0, "R8 R9 per-lane bypass");
        acc(0, 1, 2'b11, 8'h20, SEL, 0, 1, 0, 18'h11111, "R9 no lanes");
        acc(0, 0, 2'b11, 8'h20, SEL, 0, 1, 0, '0, "R9 no lanes kept");
        // R5 R6: linear write burst from offset 2 with wrap
        acc(0, 1, 2'b00, 8'h42, SEL, 0, 1, 0, 18'h00100, "R5 lin load");
        acc(1, 0, 2'b00, 8'h00, 3'b101, 0, 0, 0, 18'h00201, "R5 R6 lin beat1");
        acc(1, 0, 2'b00, 8'h00, 3'b101, 0, 0, 0, 18'h00302, "R5 R6 lin beat2");
        acc(1, 0, 2'b10, 8'h00, 3'b101, 0, 0, 0, 18'h3FE03, "R6 lin beat3 lane0");
        acc(0, 0, 2'b11, 8'h40, SEL, 0, 1, 0, '0, "R5 read 40");
        acc(0, 0, 2'b11, 8'h41, SEL, 0, 1, 0, '0, "R5 read 41");
        acc(0, 0, 2'b11, 8'h42, SEL, 0, 1, 0, '0, "R5 read 42");
        acc(0, 0, 2'b11, 8'h43, SEL, 0, 1, 0, '0, "R5 read 43");
        // R5 R6: interleaved read burst from offset 1, five beats wraps to start
        acc(0, 0, 2'b11, 8'h41, SEL, 0, 0, 0, '0, "R5 intl load");
        acc(1, 1, 2'b00, 8'h00, SEL, 0, 1, 0, 18'h3FFFF, "R6 intl beat1 stays read");
        acc(1, 0, 2'b11, 8'h00, SEL, 0, 1, 0, '0, "R5 intl beat2");
        acc(1, 0, 2'b11, 8'h00, SEL, 0, 1, 0, '0, "R5 intl beat3");
        acc(1, 0, 2'b11, 8'h00, SEL, 0, 1, 0, '0, "R5 intl wrap");
        // R4: deselected loads write nothing and drive nothing
        acc(0, 1, 2'b00, 8'h10, 3'b110, 0, 1, 0, 18'h12345, "R4 desel write a");
        acc(0, 1, 2'b00, 8'h10, 3'b000, 0, 1, 0, 18'h12345, "R4 desel write b");
        acc(0, 0, 2'b11, 8'h10, 3'b011, 0, 1, 0, '0, "R4 desel read");
        acc(1, 0, 2'b11, 8'h00, SEL, 0, 1, 0, '0, "R4 R6 advance after deselect");
        acc(0, 0, 2'b11, 8'h10, SEL, 0, 1, 0, '0, "R4 read 10 unchanged");
        // R7: sleep blocks a write and freezes a burst
        acc(0, 1, 2'b00, 8'h21, SEL, 1, 1, 0, 18'h2FFFF, "R7 sleep write");
        acc(0, 0, 2'b11, 8'h21, SEL, 0, 1, 0, '0, "R7 read 21 unchanged");
        acc(1, 0, 2'b11, 8'h00, SEL, 1, 1, 0, '0, "R7 sleep during burst");
        acc(1, 0, 2'b11, 8'h00, SEL, 0, 1, 0, '0, "R7 burst resumes");
        // R10: output enable gating
        acc(0, 0, 2'b11, 8'h22, SEL, 0, 1, 1, '0, "R10 read with oe off");
        acc(0, 0, 2'b11, 8'h22, SEL, 0, 1, 0, '0, "R10 read with oe on");
        acc(0, 1, 2'b00, 8'h23, SEL, 0, 1, 0, 18'h01234, "R10 write not driven");
        idle("R10 tail");
        idle("R10 tail");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule